// File: doc/BRIEF.md
# SHA-2 Message Padding Sequencer

This block sits between a message word queue and a SHA-2 compression engine. It passes whole message words through to the engine. Once software marks the message complete, it appends the standard padding: a single one bit (a 0x80 byte), enough zero words to reach the length slot of the final block, and the message length in bits written as two words. One instance covers both word sizes. With 32-bit words it builds 512-bit blocks (SHA-256). With 64-bit words it builds 1024-bit blocks (SHA-384/512). The word size is chosen per message from the mode captured at start.

Words are big-endian: the first message byte is the most significant byte of a word. The output bus is always 64 bits wide. In 32-bit mode only its low half carries data and the upper half reads zero. A message may end part-way through a word. In that case the block takes that final queue word and keeps the valid bytes. It writes the marker byte right after them and zeroes the rest. The message length must be a whole number of bytes.

Transfers to the engine use a valid/ready pair. The queue side has a valid input and a pop output, and the pop fires in the cycle a queue word is accepted downstream. The bit counter is cleared by a start strobe and kept by a continue strobe, so a message can be resumed after earlier blocks.

Top module: `sha2_pad_seq`

## Requirements
- R1: After reset, and in the idle state, `out_valid_o` and `fifo_pop_o` are low. The block leaves idle only in a cycle where `en_i` is high and `start_i` or `cont_i` is high.
- R2: While `en_i` is low, `out_valid_o` and `fifo_pop_o` are low, and the block is back in idle at the next clock edge, from any state.
- R3: The mode `mode_i` is captured when `start_i` is high and ignored at other times. The encodings are 0 = none, 1 = 32-bit words, 2 and 3 = 64-bit words. The captured mode is cleared to none (32-bit behaviour) when `done_i` is high.
- R4: A completion flag is set by `proc_i` and cleared by `done_i`, by start/continue or by `en_i` low. Clearing takes priority over setting. No marker word is emitted until the flag is set.
- R5: Each whole message word is forwarded from the queue with `fifo_pop_o` in the same cycle it is accepted. In 32-bit mode the data is `fifo_data_i[31:0]` and bits [63:32] of the output are zero.
- R6: The marker word keeps the first r valid bytes of the last queue word, puts 0x80 in byte r counted from the most significant end, and zeroes the rest. r is `msg_len_i[4:3]` in 32-bit mode and `msg_len_i[5:3]` in 64-bit mode. The queue is popped when this word is accepted.
- R7: When r is 0, the marker word is 0x80 in the top byte with all other bytes zero. It is emitted without needing or popping a queue word.
- R8: Zero words follow the marker until the next word would sit two words before the end of a block (512 bits in 32-bit mode, 1024 bits in 64-bit mode). When the marker already sits there, no zero word is emitted.
- R9: The two length words are {32'b0, len[63:32]} then {32'b0, len[31:0]} in 32-bit mode, and len[127:64] then len[63:0] in 64-bit mode.
- R10: No word advances without `out_ready_i`. The block returns to idle, with `out_valid_o` low, the cycle after the low length word is accepted.
- R11: The bit counter is cleared by `start_i` and kept by `cont_i`. It advances by the word width on every accepted word, including padding. A start or continue restarts message intake from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low aborts to idle |
| start_i | input | 1 | Begin a new message: clears counter, captures mode |
| cont_i | input | 1 | Resume a message keeping the bit counter |
| proc_i | input | 1 | Message complete; padding may begin |
| done_i | input | 1 | Hash finished; clears mode and completion flag |
| mode_i | input | 2 | Word-size mode, captured on start |
| msg_len_i | input | 128 | Total message length in bits |
| fifo_valid_i | input | 1 | Queue holds a word |
| fifo_data_i | input | 64 | Queue head word |
| fifo_pop_o | output | 1 | Pop the queue head |
| out_valid_o | output | 1 | Word offered to the engine |
| out_data_o | output | 64 | Word to the engine |
| out_ready_i | input | 1 | Engine accepts the word |

## Verification
The bench goes after every marker byte position in both word sizes, because a wrong shift or mask leaks garbage bytes or misplaces the 0x80. It also covers messages whose marker lands exactly at the length slot and messages one word past it. A design with the block-fill test off by one word would emit a spurious extra block or overwrite the length. Stalls on both ready and queue valid expose a design that advances without a handshake, since such a design drops or repeats words. Further cases check that done drops the captured wide mode, that a missing completion flag holds padding back, and that continue keeps the counter where start clears it. Getting any of these wrong shows up as the wrong word count or the wrong length placement.

// File: rtl/sha2pad_pkg.sv
package sha2pad_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_S256 = 2'd1,
    MODE_S384 = 2'd2,
    MODE_S512 = 2'd3
  } pad_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FEED = 3'd1,
    ST_MARK = 3'd2,
    ST_ZERO = 3'd3,
    ST_LHI  = 3'd4,
    ST_LLO  = 3'd5
  } pad_st_e;

endpackage

// File: rtl/sha2pad_ctl.sv
module sha2pad_ctl
  import sha2pad_pkg::*;
#(
  parameter int  DW         = 64,
  parameter int  LEN_W      = 128,
  parameter bit  MULTI_MODE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             proc_i,
  input  logic             done_i,
  input  logic [1:0]       mode_i,
  input  logic             word_acc_i,
  output logic             go_o,
  output logic             wide_o,
  output logic             proc_flag_o,
  output logic [LEN_W-1:0] count_o
);

  localparam int NW = DW / 2;

  pad_mode_e        mode_q, mode_d;
  logic             flag_q, flag_d;
  logic [LEN_W-1:0] count_q, count_d;
  logic             count_en;
  logic [LEN_W-1:0] step;

  assign go_o   = start_i | cont_i;
  assign wide_o = MULTI_MODE && ((mode_q == MODE_S384) || (mode_q == MODE_S512));
  assign step   = wide_o ? LEN_W'(DW) : LEN_W'(NW);

  always_comb begin
    if (start_i)     mode_d = pad_mode_e'(mode_i);
    else if (done_i) mode_d = MODE_NONE;
    else             mode_d = mode_q;
  end

  always_comb begin
    if (!en_i || go_o || done_i) flag_d = 1'b0;
    else if (proc_i)             flag_d = 1'b1;
    else                         flag_d = flag_q;
  end

  assign count_en = start_i | word_acc_i;
  assign count_d  = start_i ? '0 : (count_q + step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NONE;
      flag_q  <= 1'b0;
      count_q <= '0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
      if (count_en) count_q <= count_d;
    end
  end

  assign proc_flag_o = flag_q;
  assign count_o     = count_q;

  p_mode_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mode_q == pad_mode_e'($past(mode_i))));
  p_mode_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> (mode_q == MODE_NONE));
  p_count_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_q == '0));
  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || done_i) |=> !flag_q);

endmodule

// File: rtl/sha2pad_fsm.sv
module sha2pad_fsm
  import sha2pad_pkg::*;
#(
  parameter int DW    = 64,
  parameter int LEN_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             go_i,
  input  logic             proc_flag_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] count_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fifo_valid_i,
  input  logic             ready_i,
  output pad_st_e          state_o,
  output logic             valid_o,
  output logic             pop_o,
  output logic             acc_o
);

  localparam int NW    = DW / 2;
  localparam int BLK_N = 16 * NW;
  localparam int BLK_W = 16 * DW;
  localparam int LBN   = $clog2(BLK_N);
  localparam int LBW   = $clog2(BLK_W);
  localparam int RWW   = $clog2(DW / 8);
  localparam int RWN   = RWW - 1;
  localparam logic [LBN-1:0] HIT_N = LBN'(BLK_N - 3 * NW);
  localparam logic [LBW-1:0] HIT_W = LBW'(BLK_W - 3 * DW);

  pad_st_e          state_q, state_d;
  logic [LEN_W-1:0] wbits;
  logic [LEN_W-1:0] rem;
  logic             room;
  logic             resid_nz;
  logic             blk_hit;

  assign wbits    = wide_i ? LEN_W'(DW) : LEN_W'(NW);
  assign rem      = len_i - count_i;
  assign room     = (rem >= wbits);
  assign resid_nz = wide_i ? (|len_i[RWW+2:3]) : (|len_i[RWN+2:3]);
  assign blk_hit  = wide_i ? (count_i[LBW-1:0] == HIT_W) : (count_i[LBN-1:0] == HIT_N);

  always_comb begin
    valid_o = 1'b0;
    case (state_q)
      ST_FEED: valid_o = fifo_valid_i && room;
      ST_MARK: valid_o = resid_nz ? fifo_valid_i : 1'b1;
      ST_ZERO,
      ST_LHI,
      ST_LLO:  valid_o = 1'b1;
      default: valid_o = 1'b0;
    endcase
    if (!en_i) valid_o = 1'b0;
  end

  assign acc_o = valid_o && ready_i;
  assign pop_o = acc_o && ((state_q == ST_FEED) || ((state_q == ST_MARK) && resid_nz));

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else if (go_i) begin
      state_d = ST_FEED;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_FEED: if (proc_flag_i && !room) state_d = ST_MARK;
        ST_MARK: if (acc_o) state_d = blk_hit ? ST_LHI : ST_ZERO;
        ST_ZERO: if (acc_o && blk_hit) state_d = ST_LHI;
        ST_LHI:  if (acc_o) state_d = ST_LLO;
        ST_LLO:  if (acc_o) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_en_low_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
  p_idle_exit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !(en_i && go_i)) |=> (state_q == ST_IDLE));
  p_pad_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_FEED) && en_i && !go_i && !proc_flag_i) |=> (state_q != ST_MARK));
  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !go_i && !ready_i && (state_q inside {ST_MARK, ST_ZERO, ST_LHI, ST_LLO}))
      |=> $stable(state_q));
  p_lenlo_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !go_i && (state_q == ST_LLO) && ready_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sha2pad_word.sv
module sha2pad_word
  import sha2pad_pkg::*;
#(
  parameter int DW    = 64,
  parameter int LEN_W = 128
) (
  input  pad_st_e          state_i,
  input  logic             wide_i,
  input  logic [DW-1:0]    fifo_data_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DW-1:0]    data_o
);

  localparam int NW  = DW / 2;
  localparam int NBW = DW / 8;
  localparam int NBN = NW / 8;
  localparam int RWW = $clog2(NBW);
  localparam int RWN = RWW - 1;

  logic [RWW-1:0] resid_w;
  logic [RWN-1:0] resid_n;
  logic [DW-1:0]  mark_w;
  logic [NW-1:0]  mark_n;

  assign resid_w = len_i[RWW+2:3];
  assign resid_n = len_i[RWN+2:3];

  for (genvar j = 0; j < NBW; j++) begin : g_wlane
    localparam logic [RWW-1:0] LJ = RWW'(j);
    assign mark_w[DW-1-8*j -: 8] = (LJ < resid_w)  ? fifo_data_i[DW-1-8*j -: 8] :
                                   (LJ == resid_w) ? 8'h80 : 8'h00;
  end

  for (genvar j = 0; j < NBN; j++) begin : g_nlane
    localparam logic [RWN-1:0] LJ = RWN'(j);
    assign mark_n[NW-1-8*j -: 8] = (LJ < resid_n)  ? fifo_data_i[NW-1-8*j -: 8] :
                                   (LJ == resid_n) ? 8'h80 : 8'h00;
  end

  always_comb begin
    data_o = '0;
    case (state_i)
      ST_FEED: data_o = wide_i ? fifo_data_i : {{NW{1'b0}}, fifo_data_i[NW-1:0]};
      ST_MARK: data_o = wide_i ? mark_w : {{NW{1'b0}}, mark_n};
      ST_LHI:  data_o = wide_i ? len_i[LEN_W-1:DW] : {{NW{1'b0}}, len_i[DW-1:NW]};
      ST_LLO:  data_o = wide_i ? len_i[DW-1:0] : {{NW{1'b0}}, len_i[NW-1:0]};
      default: data_o = '0;
    endcase
  end

endmodule

// File: rtl/sha2_pad_seq.sv
module sha2_pad_seq
  import sha2pad_pkg::*;
#(
  parameter int DW         = 64,
  parameter int LEN_W      = 2 * DW,
  parameter bit MULTI_MODE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             proc_i,
  input  logic             done_i,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] msg_len_i,
  input  logic             fifo_valid_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             fifo_pop_o,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o,
  input  logic             out_ready_i
);

  logic             go;
  logic             wide;
  logic             proc_flag;
  logic [LEN_W-1:0] count;
  logic             acc;
  pad_st_e          state;

  sha2pad_ctl #(.DW(DW), .LEN_W(LEN_W), .MULTI_MODE(MULTI_MODE)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .start_i     (start_i),
    .cont_i      (cont_i),
    .proc_i      (proc_i),
    .done_i      (done_i),
    .mode_i      (mode_i),
    .word_acc_i  (acc),
    .go_o        (go),
    .wide_o      (wide),
    .proc_flag_o (proc_flag),
    .count_o     (count)
  );

  sha2pad_fsm #(.DW(DW), .LEN_W(LEN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .go_i         (go),
    .proc_flag_i  (proc_flag),
    .wide_i       (wide),
    .count_i      (count),
    .len_i        (msg_len_i),
    .fifo_valid_i (fifo_valid_i),
    .ready_i      (out_ready_i),
    .state_o      (state),
    .valid_o      (out_valid_o),
    .pop_o        (fifo_pop_o),
    .acc_o        (acc)
  );

  sha2pad_word #(.DW(DW), .LEN_W(LEN_W)) u_word (
    .state_i     (state),
    .wide_i      (wide),
    .fifo_data_i (fifo_data_i),
    .len_i       (msg_len_i),
    .data_o      (out_data_o)
  );

  p_pop_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (out_valid_o && out_ready_i && fifo_valid_i));
  p_en_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!out_valid_o && !fifo_pop_o));
  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && !cont_i && out_valid_o && !out_ready_i && !fifo_pop_o &&
     (state inside {ST_ZERO, ST_LHI, ST_LLO}) && $stable(msg_len_i)) |=> $stable(out_data_o));

endmodule

// File: tb/tb_sha2_pad_seq.sv
`timescale 1ns/1ps
module tb_sha2_pad_seq;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en, start, cont, proc, done;
  logic [1:0]   mode;
  logic [127:0] len;
  logic         fifo_valid;
  logic [63:0]  fifo_data;
  logic         fifo_pop, out_valid, out_ready;
  logic [63:0]  out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_w [64];
  logic [63:0] got_w [64];
  int exp_n, got_n, fidx;
  bit rdy_gap, fv_gap;

  always #2 clk = ~clk;

  sha2_pad_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .cont_i(cont),
    .proc_i(proc), .done_i(done), .mode_i(mode), .msg_len_i(len),
    .fifo_valid_i(fifo_valid), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] mword(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {8'hC3, b, 8'h5A, b ^ 8'h3C, 8'h96, b + 8'd7, 8'hE1, ~b};
  endfunction

  // Behavioural padder: c0 = bits already counted, l = total length in bits.
  task automatic build_exp(input bit wide, input int c0, input int l);
    int w, blk, pos, k, r;
    logic [63:0] src, m;
    w = wide ? 64 : 32;
    blk = 16 * w;
    pos = c0; k = 0; exp_n = 0;
    while (pos + w <= l) begin
      src = mword(k);
      exp_w[exp_n] = wide ? src : {32'b0, src[31:0]};
      exp_n++; k++; pos += w;
    end
    r = (l % w) / 8;
    src = mword(k);
    if (!wide) src = {32'b0, src[31:0]};
    m = '0;
    for (int b = 0; b < w / 8; b++) begin
      if (b < r)       m[w-1-8*b -: 8] = src[w-1-8*b -: 8];
      else if (b == r) m[w-1-8*b -: 8] = 8'h80;
    end
    exp_w[exp_n] = m; exp_n++; pos += w;
    while ((pos % blk) != (blk - 2 * w)) begin
      exp_w[exp_n] = '0; exp_n++; pos += w;
    end
    exp_w[exp_n] = wide ? len[127:64] : {32'b0, len[63:32]}; exp_n++;
    exp_w[exp_n] = wide ? len[63:0]   : {32'b0, len[31:0]};  exp_n++;
  endtask

  task automatic drop_first();
    for (int i = 1; i < exp_n; i++) exp_w[i-1] = exp_w[i];
    exp_n--;
  endtask

  task automatic kick(input logic [1:0] m, input int l, input bit use_cont);
    @(negedge clk);
    en = 1'b1; mode = m; len = 128'(l);
    start = !use_cont; cont = use_cont;
    fifo_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; cont = 1'b0; proc = 1'b1;
    @(negedge clk);
    proc = 1'b0;
    fidx = 0;
  endtask

  task automatic run_stream(input string req);
    int cy;
    bit fin;
    cy = 0; fin = 0; got_n = 0;
    while (!fin && cy < 600) begin
      @(negedge clk);
      cy++;
      out_ready  = !(rdy_gap && (cy % 4 == 2));
      fifo_valid = !(fv_gap && (cy % 3 == 1));
      fifo_data  = mword(fidx);
      #1;
      if (out_valid && out_ready) begin
        if (got_n < 64) got_w[got_n] = out_data;
        got_n++;
        if (got_n == exp_n) fin = 1;
      end
      if (fifo_pop) fidx++;
    end
    chk(got_n == exp_n, {req, " word count"}, 128'(got_n), 128'(exp_n));
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
      chk(got_w[i] == exp_w[i], {req, " word"}, {64'(i), got_w[i]}, {64'(i), exp_w[i]});
    @(negedge clk);
    out_ready = 1'b1; fifo_valid = 1'b1;
    #1;
    chk(!out_valid, "R10 idle after low length word", 128'(out_valid), 128'(0));
    out_ready = 1'b0; fifo_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(!out_valid && !fifo_pop, "R1 reset state", {out_valid, fifo_pop}, 128'(0));
  endtask

  task automatic t_idle_noen();
    @(negedge clk);
    en = 1'b0; start = 1'b1; mode = 2'd1; len = 128'd64;
    @(negedge clk);
    start = 1'b0; en = 1'b1; fifo_valid = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!out_valid && !fifo_pop, "R1 stays idle without enabled go", {out_valid, fifo_pop}, 128'(0));
    end
    fifo_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic t_pad(input logic [1:0] m, input int l, input bit rg, input bit fg, input string req);
    rdy_gap = rg; fv_gap = fg;
    kick(m, l, 1'b0);
    build_exp(m >= 2'd2, 0, l);
    run_stream(req);
    rdy_gap = 0; fv_gap = 0;
  endtask

  task automatic t_en_drop();
    kick(2'd1, 200, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); out_ready = 1'b1; fifo_valid = 1'b1; fifo_data = mword(fidx);
      #1; if (fifo_pop) fidx++;
    end
    @(negedge clk); en = 1'b0; #1;
    chk(!out_valid && !fifo_pop, "R2 enable low silences outputs", {out_valid, fifo_pop}, 128'(0));
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!out_valid, "R2 back in idle after enable low", 128'(out_valid), 128'(0));
    end
    out_ready = 1'b0; fifo_valid = 1'b0;
  endtask

  task automatic t_restart();
    kick(2'd1, 200, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); out_ready = 1'b1; fifo_valid = 1'b1; fifo_data = mword(fidx);
      #1; if (fifo_pop) fidx++;
    end
    kick(2'd1, 40, 1'b0);
    build_exp(1'b0, 0, 40);
    run_stream("R11 start restarts mid-message");
  endtask

  task automatic t_continue();
    kick(2'd1, 416, 1'b0);
    build_exp(1'b0, 0, 416);
    run_stream("R8 marker at length slot");
    kick(2'd1, 552, 1'b1);
    build_exp(1'b0, 512, 552);
    run_stream("R11 continue keeps counter");
  endtask

  task automatic t_capture();
    kick(2'd3, 40, 1'b0);
    mode = 2'd1;
    build_exp(1'b1, 0, 40);
    run_stream("R3 mode held after start");
  endtask

  task automatic t_done_mode();
    @(negedge clk);
    en = 1'b1; mode = 2'd3; len = 128'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0; proc = 1'b1;
    @(negedge clk);
    proc = 1'b0; fidx = 0;
    build_exp(1'b0, 0, 40);
    run_stream("R3 done clears wide mode");
  endtask

  task automatic t_flag_gate();
    @(negedge clk);
    en = 1'b1; mode = 2'd1; len = 128'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0; proc = 1'b1;
    @(negedge clk);
    proc = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0; fidx = 0; got_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); out_ready = 1'b1; fifo_valid = 1'b1; fifo_data = mword(fidx);
      #1;
      if (out_valid && out_ready) got_n++;
      if (fifo_pop) fidx++;
    end
    chk(got_n == 1, "R4 padding held without completion flag", 128'(got_n), 128'(1));
    @(negedge clk); out_ready = 1'b0; fifo_valid = 1'b0; proc = 1'b1;
    @(negedge clk); proc = 1'b0;
    build_exp(1'b0, 0, 40);
    drop_first();
    run_stream("R4 padding after completion flag");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; cont = 1'b0; proc = 1'b0; done = 1'b0;
    mode = 2'd0; len = '0; fifo_valid = 1'b0; fifo_data = '0; out_ready = 1'b0;
    rdy_gap = 0; fv_gap = 0; fidx = 0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_idle_noen();
    // 32-bit mode: residual bytes 0..3, block boundary, extra block
    t_pad(2'd1, 416, 0, 0, "R7 narrow no residual at slot");
    t_pad(2'd1, 424, 0, 0, "R6 narrow residual 1");
    t_pad(2'd1, 48,  1, 0, "R6 narrow residual 2 with stalls");
    t_pad(2'd1, 440, 0, 1, "R6 narrow residual 3 queue gaps");
    t_pad(2'd1, 0,   0, 0, "R7 narrow empty message");
    t_pad(2'd1, 448, 1, 1, "R8 narrow spills to next block");
    t_pad(2'd1, 96,  0, 0, "R5 narrow whole words");
    // 64-bit mode
    t_pad(2'd3, 832, 0, 0, "R8 wide marker at slot");
    t_pad(2'd3, 8,   0, 0, "R6 wide residual 1");
    t_pad(2'd3, 16,  1, 0, "R6 wide residual 2");
    t_pad(2'd2, 24,  0, 0, "R6 wide residual 3");
    t_pad(2'd3, 32,  0, 1, "R6 wide residual 4");
    t_pad(2'd2, 40,  0, 0, "R6 wide residual 5");
    t_pad(2'd3, 48,  0, 0, "R6 wide residual 6");
    t_pad(2'd3, 56,  1, 1, "R6 wide residual 7");
    t_pad(2'd3, 896, 0, 0, "R9 wide spills to next block");
    t_pad(2'd2, 128, 1, 0, "R5 wide whole words");
    t_en_drop();
    t_restart();
    t_continue();
    t_capture();
    t_done_mode();
    t_flag_gate();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule